// File: doc/BRIEF.md
# Serial Flash Master with Register Port

This block is a serial-peripheral master for one flash device, driven through a 32-bit word-addressed register port. Software fills a small transmit queue and programs a command word. The command word holds the transfer length, the enables for each direction, the clock idle level and sampling phase, and the chip-select controls. Software then sets a start bit. The block shifts one word of 1 to 32 bits onto the serial data output, most significant bit first. At the same time it captures the serial input. It places the captured word in a receive queue and raises a sticky completion flag.

The serial clock runs from a one-cycle enable pulse, `sck_tick`, that a divider outside the block produces. Each tick moves the serial clock by one edge. Software can hold chip select through a value bit whose sense is the inverse of the pin. Otherwise the hardware asserts chip select for exactly the cycles of a shift. Error and completion events stay set until software writes ones to them. Writing back the status value just read clears every pending event.

Register map (byte address, bits [1:0] must be zero): 0x00 command, 0x04 status, 0x10 transmit data port (write), 0x20 receive data port (read). All other addresses read as zero and ignore writes.

Top module: `spi_flash_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, the command register reads 0, and status reads 0x02800000, meaning only the receive-empty flag (bit 25) and the transmit-empty flag (bit 23) are set.
- R2: The command register keeps bits [4:0] (length minus one), bit 12 (software select), bit 13 (select value), bit 14 (receive enable), bit 15 (transmit enable), bits [19:18] and bits [27:26]. All other bits read 0, including the start bit 30, so writing 0xBFFFFFFF reads back 0x0C0CF01F.
- R3: The transmit queue holds 4 words, and status bit 22 shows it full. A write to the full queue drops the word and sets the sticky overflow flag, status bit 26.
- R4: A read of the receive port while the receive queue is empty returns 0 and sets the sticky underrun flag, status bit 27.
- R5: Status bits 30, 27 and 26 clear only when a 1 is written to them. Writing 1 to bit 29 empties the receive queue and writing 1 to bit 28 empties the transmit queue. Both of those bits always read 0.
- R6: Writing the command register with bit 30 set while idle starts a shift. Status bit 31 (busy) reads 1 on the next access. The serial output carries the low N bits of the transmit word, most significant first, where N is the length field plus one.
- R7: When the shift ends, busy clears and the sticky ready flag (bit 30) sets. If receive is enabled, the captured N bits enter the receive queue right-aligned, with the last bit received in bit 0.
- R8: A start request while busy has no effect. No transmit word is consumed and no extra clock pulses are produced.
- R9: With bit 12 set, `spi_cs_n` is the inverse of bit 13, one cycle after the register write. With bit 12 clear, `spi_cs_n` is low exactly while busy.
- R10: Command bit 26 sets the clock idle level. Command bit 18 clear samples the input on the leading clock edge and changes the output on the trailing edge. Bit 18 set does the reverse. A transfer has exactly N sampling edges.
- R11: With transmit disabled (bit 15 clear), the output shifts zeros and the transmit queue is not consumed. With receive disabled (bit 14 clear), nothing enters the receive queue.
- R12: During a shift, the serial clock changes only in the cycle after `sck_tick` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive port) |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| sck_tick | input | 1 | Serial clock edge enable from external divider |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Assertions check four things on every cycle. Overflow and underrun must follow an access to a full or empty queue. Ready must be set when busy falls. No transmit word may be consumed while busy. Chip select must follow either the value bit or busy, depending on the mode. They also check that the serial clock moves only after a tick during a shift. The bench scenarios cover the properties that need a live serial partner. These are the bit order in both phase settings and at widths of 8, 12 and 32 bits, the right alignment of received data, and that a repeated start request produces no second shift. They also cover the drop of the fifth queued word and the zero-fill when transmit is disabled.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // register word indices (byte address >> 2)
    localparam int RIX_CMD  = 0;
    localparam int RIX_STAT = 1;
    localparam int RIX_TXD  = 4;
    localparam int RIX_RXD  = 8;

    // command bit positions
    localparam int CB_GO    = 30;
    localparam int CB_CPOL  = 26;
    localparam int CB_CPHA  = 18;
    localparam int CB_TXEN  = 15;
    localparam int CB_RXEN  = 14;
    localparam int CB_CSVAL = 13;
    localparam int CB_CSSW  = 12;
    localparam logic [31:0] CMD_KEEP = 32'h0C0C_F01F;

    // status bit positions
    localparam int SB_BUSY  = 31;
    localparam int SB_RDY   = 30;
    localparam int SB_RXFL  = 29;
    localparam int SB_TXFL  = 28;
    localparam int SB_UNR   = 27;
    localparam int SB_OVF   = 26;
    localparam int SB_RXE   = 25;
    localparam int SB_RXF   = 24;
    localparam int SB_TXE   = 23;
    localparam int SB_TXF   = 22;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_RUN  = 2'd1,
        SH_DONE = 2'd2
    } sh_state_e;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  push_ok, pop_ok;

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CW'(DEPTH));
    assign dout    = q.mem[q.rd];
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        d = q;
        if (flush) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end else begin
            if (push_ok) begin
                d.mem[q.wr] = din;
                d.wr = (q.wr == PW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
            end
            if (pop_ok) begin
                d.rd = (q.rd == PW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
            end
            d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 start,
    input  logic [W-1:0]         word,
    input  logic [$clog2(W)-1:0] len_m1,
    input  logic                 cpol,
    input  logic                 cpha,
    input  logic                 miso,
    output logic                 busy,
    output logic                 done,
    output logic [W-1:0]         rx_word,
    output logic                 sck,
    output logic                 mosi
);
    localparam int LW = $clog2(W);

    typedef struct packed {
        sh_state_e     st;
        logic [W-1:0]  sh;
        logic [W-1:0]  rx;
        logic [LW-1:0] bits;
        logic [LW-1:0] len;
        logic          lead;
        logic          cpha;
        logic          sck;
        logic          mosi;
    } sh_t;

    sh_t          q, d;
    logic [W-1:0] aligned;

    assign aligned = word << (LW'(W - 1) - len_m1);
    assign busy    = (q.st != SH_IDLE);
    assign done    = (q.st == SH_DONE);
    assign rx_word = q.rx;
    assign sck     = q.sck;
    assign mosi    = q.mosi;

    always_comb begin
        d = q;
        case (q.st)
            SH_IDLE: begin
                d.sck = cpol;
                if (start) begin
                    d.st   = SH_RUN;
                    d.len  = len_m1;
                    d.cpha = cpha;
                    d.bits = '0;
                    d.lead = 1'b1;
                    d.rx   = '0;
                    if (cpha) begin
                        d.sh = aligned;
                    end else begin
                        d.mosi = aligned[W-1];
                        d.sh   = aligned << 1;
                    end
                end
            end
            SH_RUN: begin
                if (tick) begin
                    d.sck = ~q.sck;
                    if (q.lead) begin
                        d.lead = 1'b0;
                        if (q.cpha) begin
                            d.mosi = q.sh[W-1];
                            d.sh   = q.sh << 1;
                        end else begin
                            d.rx = {q.rx[W-2:0], miso};
                        end
                    end else begin
                        d.lead = 1'b1;
                        if (q.cpha) begin
                            d.rx = {q.rx[W-2:0], miso};
                        end else begin
                            d.mosi = q.sh[W-1];
                            d.sh   = q.sh << 1;
                        end
                        if (q.bits == q.len) d.st = SH_DONE;
                        else                 d.bits = q.bits + 1'b1;
                    end
                end
            end
            SH_DONE: d.st = SH_IDLE;
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
    import spim_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_tick,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    localparam int LW = $clog2(DATA_W);
    localparam int IW = ADDR_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        logic              rdy;
        logic              unr;
        logic              ovf;
        logic              cs_n;
    } ctl_t;

    localparam ctl_t CTL_RST = '{cmd: '0, rdy: 1'b0, unr: 1'b0, ovf: 1'b0, cs_n: 1'b1};

    ctl_t q, d;

    logic [IW-1:0]     ridx;
    logic              aligned_acc;
    logic              sel_cmd, sel_stat, sel_txd, sel_rxd;
    logic              wr_cmd, wr_stat, tx_wr_req, rx_rd_req;
    logic              start, tx_pop, rx_push, tx_flush, rx_flush;
    logic              busy, sh_done, cs_soft, cs_val;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [DATA_W-1:0] tx_dout, rx_dout, sh_word, sh_rx;
    logic              ovf_flag, unr_flag, rdy_flag;

    assign ridx        = bus_addr[ADDR_W-1:2];
    assign aligned_acc = (bus_addr[1:0] == 2'b00);
    assign sel_cmd     = aligned_acc && (ridx == IW'(RIX_CMD));
    assign sel_stat    = aligned_acc && (ridx == IW'(RIX_STAT));
    assign sel_txd     = aligned_acc && (ridx == IW'(RIX_TXD));
    assign sel_rxd     = aligned_acc && (ridx == IW'(RIX_RXD));

    assign wr_cmd    = bus_wr && sel_cmd;
    assign wr_stat   = bus_wr && sel_stat;
    assign tx_wr_req = bus_wr && sel_txd;
    assign rx_rd_req = bus_rd && sel_rxd;

    assign cs_soft  = q.cmd[CB_CSSW];
    assign cs_val   = q.cmd[CB_CSVAL];
    assign ovf_flag = q.ovf;
    assign unr_flag = q.unr;
    assign rdy_flag = q.rdy;

    assign start    = wr_cmd && bus_wdata[CB_GO] && !busy;
    assign tx_pop   = start && q.cmd[CB_TXEN] && !tx_empty;
    assign sh_word  = (q.cmd[CB_TXEN] && !tx_empty) ? tx_dout : '0;
    assign rx_push  = sh_done && q.cmd[CB_RXEN];
    assign tx_flush = wr_stat && bus_wdata[SB_TXFL];
    assign rx_flush = wr_stat && bus_wdata[SB_RXFL];

    spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_wr_req), .din(bus_wdata), .pop(tx_pop),
        .dout(tx_dout), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(rx_push), .din(sh_rx), .pop(rx_rd_req),
        .dout(rx_dout), .empty(rx_empty), .full(rx_full)
    );

    spim_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(sck_tick), .start(start),
        .word(sh_word), .len_m1(q.cmd[LW-1:0]),
        .cpol(q.cmd[CB_CPOL]), .cpha(q.cmd[CB_CPHA]), .miso(spi_miso),
        .busy(busy), .done(sh_done), .rx_word(sh_rx),
        .sck(spi_sck), .mosi(spi_mosi)
    );

    always_comb begin
        d = q;
        if (wr_cmd) d.cmd = bus_wdata & CMD_KEEP;
        d.rdy = (q.rdy && !(wr_stat && bus_wdata[SB_RDY])) || sh_done;
        d.unr = (q.unr && !(wr_stat && bus_wdata[SB_UNR])) || (rx_rd_req && rx_empty);
        d.ovf = (q.ovf && !(wr_stat && bus_wdata[SB_OVF])) || (tx_wr_req && tx_full);
        if (q.cmd[CB_CSSW]) d.cs_n = !q.cmd[CB_CSVAL];
        else                d.cs_n = !(start || (busy && !sh_done));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_cmd) begin
            bus_rdata = q.cmd;
        end else if (sel_stat) begin
            bus_rdata[SB_BUSY] = busy;
            bus_rdata[SB_RDY]  = q.rdy;
            bus_rdata[SB_UNR]  = q.unr;
            bus_rdata[SB_OVF]  = q.ovf;
            bus_rdata[SB_RXE]  = rx_empty;
            bus_rdata[SB_RXF]  = rx_full;
            bus_rdata[SB_TXE]  = tx_empty;
            bus_rdata[SB_TXF]  = tx_full;
        end else if (sel_rxd) begin
            bus_rdata = rx_empty ? '0 : rx_dout;
        end
    end

    assign spi_cs_n = q.cs_n;

endmodule

// File: rtl/spim_checker.sv
module spim_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic cs_soft,
    input logic cs_val,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic sck_tick,
    input logic tx_wr_req,
    input logic tx_full,
    input logic ovf_flag,
    input logic rx_rd_req,
    input logic rx_empty,
    input logic unr_flag,
    input logic rdy_flag,
    input logic tx_pop
);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_req && tx_full) |=> ovf_flag);

    assert_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_req && rx_empty) |=> unr_flag);

    assert_ready_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rdy_flag);

    assert_no_pop_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_pop);

    assert_cs_soft_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_soft) |-> (spi_cs_n == !$past(cs_val)));

    assert_cs_hw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cs_soft) |-> (spi_cs_n == !busy));

    assert_sck_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(spi_sck) && $past(busy)) |-> $past(sck_tick));

endmodule

bind spi_flash_master spim_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cs_soft(cs_soft), .cs_val(cs_val),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .sck_tick(sck_tick),
    .tx_wr_req(tx_wr_req), .tx_full(tx_full), .ovf_flag(ovf_flag),
    .rx_rd_req(rx_rd_req), .rx_empty(rx_empty), .unr_flag(unr_flag),
    .rdy_flag(rdy_flag), .tx_pop(tx_pop)
);

// File: tb/sim_spi_flash_master.sv
`timescale 1ns/1ps
module sim_spi_flash_master;
    localparam int TICK_DIV = 3;
    localparam logic [31:0] C_GO = 32'h4000_0000, C_CPOL = 32'h0400_0000,
        C_CPHA = 32'h0004_0000, C_TX = 32'h0000_8000, C_RX = 32'h0000_4000,
        C_VAL = 32'h0000_2000, C_SW = 32'h0000_1000;

    logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, sck_tick = 0, spi_miso = 0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic spi_sck, spi_mosi, spi_cs_n;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic soft_m = 0, val_m = 0, pipe_en = 0, pipe_val = 0;
    logic cpol_m = 0, cpha_m = 0, prev_sck = 0;
    logic [31:0] s_pat = '0, s_cap = '0, rv;
    int s_idx = -1, s_n = 0;

    spi_flash_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_tick(sck_tick), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // tick generator
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            sck_tick = (cnt == TICK_DIV - 1);
            cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
        end
    end

    // model pipeline for chip select: register the expectation at each edge
    initial forever begin
        @(posedge clk);
        pipe_en  = soft_m;
        pipe_val = val_m;
    end

    // per-clock comparison and serial slave model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pipe_en) check("R9 cs per cycle", {31'b0, spi_cs_n}, {31'b0, !pipe_val});
                if (spi_sck !== prev_sck) begin
                    logic lead;
                    lead = (spi_sck != cpol_m);
                    if (lead != cpha_m) begin
                        s_cap = {s_cap[30:0], spi_mosi};
                        s_n++;
                        s_idx--;
                        if (s_idx >= 0) spi_miso = s_pat[s_idx];
                    end
                end
            end
            prev_sck = spi_sck;
        end
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic bus_write(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic set_cmd(input logic [31:0] v);
        bus_write(6'h00, v);
        soft_m = v[12];
        val_m  = v[13];
        cpol_m = v[26];
        cpha_m = v[18];
    endtask

    task automatic start_slave(input logic [31:0] pat, input int len);
        s_pat = pat; s_cap = '0; s_n = 0; s_idx = len - 1;
        spi_miso = pat[len-1];
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        int n = 0;
        do begin
            bus_read(6'h04, st);
            n++;
        end while (st[31] && n < 3000);
    endtask

    initial begin
        logic [31:0] base;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 cs_n after reset", {31'b0, spi_cs_n}, 32'd1);
        bus_read(6'h04, rv); check("R1 status after reset", rv, 32'h0280_0000);
        bus_read(6'h00, rv); check("R1 command after reset", rv, 32'h0);

        // R2 command field storage
        bus_write(6'h00, 32'hBFFF_FFFF);
        bus_read(6'h00, rv); check("R2 command readback", rv, 32'h0C0C_F01F);
        set_cmd(32'h0);
        repeat (3) @(negedge clk);

        // R9 software select
        set_cmd(C_SW | C_VAL);
        @(negedge clk);
        check("R9 soft select asserted", {31'b0, spi_cs_n}, 32'd0);
        set_cmd(C_SW);
        @(negedge clk);
        check("R9 soft select released", {31'b0, spi_cs_n}, 32'd1);

        // R6 R7 mode 0, 8 bits
        base = C_TX | C_RX | C_SW | C_VAL | 32'd7;
        set_cmd(base);
        repeat (3) @(negedge clk);
        start_slave(32'h3C, 8);
        bus_write(6'h10, 32'hA5);
        set_cmd(base | C_GO);
        bus_read(6'h04, rv); check("R6 busy after start", {31'b0, rv[31]}, 32'd1);
        wait_idle();
        check("R6 serial out 8-bit", s_cap, 32'hA5);
        check("R10 sample count 8", s_n, 32'd8);
        bus_read(6'h04, rv);
        check("R7 ready set, rx not empty, tx empty", rv & 32'hC280_0000, 32'h4080_0000);
        bus_read(6'h20, rv); check("R7 received word", rv, 32'h3C);

        // R10 mode 3, 32 bits
        base = C_TX | C_RX | C_SW | C_VAL | C_CPOL | C_CPHA | 32'd31;
        set_cmd(base);
        repeat (4) @(negedge clk);
        check("R10 idle clock high", {31'b0, spi_sck}, 32'd1);
        start_slave(32'hCAFE_F00D, 32);
        bus_write(6'h10, 32'h1234_5678);
        set_cmd(base | C_GO);
        wait_idle();
        check("R6 serial out 32-bit mode 3", s_cap, 32'h1234_5678);
        check("R10 sample count 32", s_n, 32'd32);
        bus_read(6'h20, rv); check("R7 received 32-bit", rv, 32'hCAFE_F00D);

        // R9 hardware select, phase 1, 12 bits
        base = C_TX | C_RX | C_CPHA | 32'd11;
        set_cmd(base);
        repeat (4) @(negedge clk);
        check("R9 hw select idle high", {31'b0, spi_cs_n}, 32'd1);
        start_slave(32'h5A3, 12);
        bus_write(6'h10, 32'hFFFF_FABC);
        set_cmd(base | C_GO);
        check("R9 hw select low while busy", {31'b0, spi_cs_n}, 32'd0);
        wait_idle();
        check("R9 hw select high after", {31'b0, spi_cs_n}, 32'd1);
        check("R6 serial out 12-bit", s_cap, 32'hABC);
        bus_read(6'h20, rv); check("R7 right-aligned 12-bit", rv, 32'h5A3);

        // R8 start while busy
        base = C_TX | C_RX | C_SW | C_VAL | 32'd7;
        set_cmd(base);
        repeat (3) @(negedge clk);
        start_slave(32'h81, 8);
        bus_write(6'h10, 32'h11);
        bus_write(6'h10, 32'h22);
        set_cmd(base | C_GO);
        set_cmd(base | C_GO);
        wait_idle();
        repeat (80) @(negedge clk);
        check("R8 only one shift", s_n, 32'd8);
        check("R8 first word sent", s_cap, 32'h11);
        bus_read(6'h04, rv); check("R8 second word kept", {31'b0, rv[23]}, 32'd0);
        bus_read(6'h20, rv); check("R8 one receive entry", rv, 32'h81);
        bus_read(6'h20, rv); check("R4 empty read returns zero", rv, 32'h0);
        bus_read(6'h04, rv); check("R4 underrun set", rv & 32'h4C00_0000, 32'h4800_0000);

        // R5 write-one-to-clear and flush
        bus_write(6'h04, 32'h0);
        bus_read(6'h04, rv); check("R5 zero write keeps flags", rv & 32'h4800_0000, 32'h4800_0000);
        bus_write(6'h04, 32'h0800_0000);
        bus_read(6'h04, rv); check("R5 clear underrun only", rv & 32'h4800_0000, 32'h4000_0000);
        bus_write(6'h04, rv);
        bus_read(6'h04, rv); check("R5 write-back clears ready", {31'b0, rv[30]}, 32'd0);
        bus_write(6'h04, 32'h1000_0000);
        bus_read(6'h04, rv); check("R5 tx flush empties, flush bits read 0", rv & 32'h3080_0000, 32'h0080_0000);

        // R3 overflow then drain
        for (int i = 1; i <= 4; i++) bus_write(6'h10, i);
        bus_read(6'h04, rv); check("R3 full without overflow", rv & 32'h0440_0000, 32'h0040_0000);
        bus_write(6'h10, 32'h5);
        bus_read(6'h04, rv); check("R3 overflow set", {31'b0, rv[26]}, 32'd1);
        base = C_TX | C_SW | C_VAL | 32'd7;
        set_cmd(base);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            start_slave(32'h0, 8);
            set_cmd(base | C_GO);
            wait_idle();
        end
        check("R3 fifth word dropped", s_cap, 32'h04);
        bus_read(6'h04, rv); check("R11 no receive when disabled", rv & 32'h0280_0000, 32'h0280_0000);

        // R11 transmit disabled
        base = C_RX | C_SW | C_VAL | 32'd7;
        set_cmd(base);
        repeat (3) @(negedge clk);
        bus_write(6'h10, 32'hFF);
        start_slave(32'h96, 8);
        set_cmd(base | C_GO);
        wait_idle();
        check("R11 zeros shifted", s_cap, 32'h0);
        bus_read(6'h04, rv); check("R11 tx word not consumed", {31'b0, rv[23]}, 32'd0);
        bus_read(6'h20, rv); check("R11 receive still works", rv, 32'h96);
        bus_write(6'h04, 32'h1000_0000);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule